// File: doc/BRIEF.md
# Critical-Word-First Line Refill Responder

This block sits on the memory side of a cache refill link. A cache controller that misses places one request word on an incoming FIFO-style link. The request carries the missed byte address and a control bit. The responder pops that request, reads the whole line that holds the address from its internal word store, and pushes the line one 32-bit word at a time into a response buffer. The receiver drains that buffer through an exists/read handshake.

The line holds 4 or 8 words. The build-time choice `WRAP_FIRST` sets the return order. With `WRAP_FIRST = 1` the missed word comes out first, so the controller can resume after a single beat, and the index then wraps inside the line. With `WRAP_FIRST = 0` the line comes out in ascending order from its aligned base. The responder handles one request at a time. It does not take another request until every word of the current line has been placed in the response buffer.

Top module: `refill_responder`

## Requirements
- R1: During reset and at its release, `rsp_exists` is low and the sequencer is idle, so no response word is visible.
- R2: With `WRAP_FIRST = 1`, a read request whose word index is i returns LINE_WORDS words. Beat k carries the word at line base plus ((i mod LINE_WORDS) + k) mod LINE_WORDS. For example, with 4-word lines, byte address 0x348 yields words from 0x348, 0x34C, 0x340 and 0x344.
- R3: With `WRAP_FIRST = 0`, beat k carries the word at line base plus k, whatever the low index bits of the request.
- R4: Each read request yields exactly LINE_WORDS words and no more. The store word at index w (byte address bits [AW+1:2], AW = log2 STORE_WORDS; higher bits are ignored) holds {w[15:0], ~w[15:0]}.
- R5: `req_read` is raised only in a cycle in which `req_exists` is high. A request is consumed on a clock edge where both are high.
- R6: Only one request is outstanding at a time. No request is popped while any word of the current line is still to be pushed into the response buffer.
- R7: A request with `req_ctrl = 1` is a non-read encoding. It is popped and discarded and produces no response word. A request with `req_ctrl = 0` is a read, whatever its address bits [1:0] hold.
- R8: The response buffer holds FIFO_DEPTH (at least LINE_WORDS) words. While it is full, no word is pushed. When `rsp_read` is held low, no word is lost or reordered.
- R9: `rsp_read` while `rsp_exists` is low has no effect. It removes nothing from the response buffer and does not disturb later words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_data | input | 32 | Request word: missed byte address |
| req_ctrl | input | 1 | Request control bit, 0 = read |
| req_exists | input | 1 | A request word is available |
| req_read | output | 1 | Pops the presented request word |
| rsp_data | output | 32 | Head word of the response buffer |
| rsp_exists | output | 1 | The response buffer is not empty |
| rsp_read | input | 1 | Pops the head response word |

## Verification
The bench builds two instances side by side. One uses 8-word lines with critical-word-first order. The other uses 4-word lines with linear order. Both use an 8-deep response buffer. The 8-word build shows the wrap of the missed word across a line boundary, and a single line fills its buffer completely. The 4-word build shows that the low index bits are ignored, and two lines fit before the buffer is full. Holding back the receiver on both builds then gives different, exactly predictable numbers of consumed requests, which tests the one-outstanding rule.

// File: rtl/refill_pkg.sv
`timescale 1ns/1ps
package refill_pkg;

  typedef enum logic {SEQ_IDLE, SEQ_FILL} seq_state_e;

  // Slot inside the line for beat number `beat` when the line wraps
  // around the critical slot.
  function automatic int wrap_slot(int crit, int beat, int len);
    return (crit + beat) % len;
  endfunction

  // Slot for either return order.
  function automatic int line_slot(bit wrap_first, int crit, int beat, int len);
    return wrap_first ? wrap_slot(crit, beat, len) : beat;
  endfunction

  // Content of store word `idx`: index in the upper half, its complement below.
  function automatic logic [31:0] seed_word(int idx);
    logic [15:0] w;
    w = 16'(idx);
    return {w, ~w};
  endfunction

endpackage

// File: rtl/refill_store.sv
`timescale 1ns/1ps
module refill_store #(
  parameter int STORE_WORDS = 256,
  localparam int AW = $clog2(STORE_WORDS)
) (
  input  logic [AW-1:0] idx,
  output logic [31:0]   word
);
  import refill_pkg::*;

  logic [31:0] cells [STORE_WORDS];

  for (genvar i = 0; i < STORE_WORDS; i++) begin : g_cell
    assign cells[i] = seed_word(i);
  end

  assign word = cells[idx];
endmodule

// File: rtl/refill_seq.sv
`timescale 1ns/1ps
module refill_seq #(
  parameter int LINE_WORDS  = 8,
  parameter int WRAP_FIRST  = 1,
  parameter int STORE_WORDS = 256,
  localparam int LW = $clog2(LINE_WORDS),
  localparam int AW = $clog2(STORE_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   req_data,
  input  logic          req_ctrl,
  input  logic          req_exists,
  output logic          req_read,
  input  logic          fifo_full,
  output logic          push,
  output logic [AW-1:0] store_idx,
  output logic          busy,
  output logic [LW-1:0] crit_o,
  output logic [LW-1:0] beat_o,
  output logic [LW-1:0] slot_o
);
  import refill_pkg::*;

  seq_state_e    state_q;
  logic [AW-1:0] base_q;
  logic [LW-1:0] crit_q, beat_q, slot;
  logic          take_req, take_read, last_beat;
  logic          unused_req_bits;

  assign unused_req_bits = ^{req_data[31:AW+2], req_data[1:0]};

  assign busy      = (state_q == SEQ_FILL);
  assign take_req  = !busy && req_exists;
  assign take_read = take_req && !req_ctrl;
  assign req_read  = take_req;
  assign push      = busy && !fifo_full;
  assign last_beat = (beat_q == LW'(LINE_WORDS - 1));

  assign slot      = LW'(line_slot(WRAP_FIRST != 0, int'(crit_q), int'(beat_q), LINE_WORDS));
  assign store_idx = base_q | AW'(slot);

  assign crit_o = crit_q;
  assign beat_o = beat_q;
  assign slot_o = slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      base_q  <= '0;
      crit_q  <= '0;
      beat_q  <= '0;
    end else if (take_read) begin
      state_q <= SEQ_FILL;
      base_q  <= req_data[AW+1:2] & ~AW'(LINE_WORDS - 1);
      crit_q  <= req_data[LW+1:2];
      beat_q  <= '0;
    end else if (push) begin
      beat_q <= beat_q + 1'b1;
      if (last_beat) state_q <= SEQ_IDLE;
    end
  end
endmodule

// File: rtl/refill_rsp_fifo.sv
`timescale 1ns/1ps
module refill_rsp_fifo #(
  parameter int FIFO_DEPTH = 8,
  localparam int PW = $clog2(FIFO_DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push,
  input  logic [31:0] wdata,
  output logic        full,
  input  logic        rd_en,
  output logic        pop,
  output logic [31:0] rdata,
  output logic        exists,
  output logic [PW:0] count
);
  logic [31:0]   slots [FIFO_DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [PW:0]   cnt_q;

  assign full   = (cnt_q == (PW+1)'(FIFO_DEPTH));
  assign exists = (cnt_q != '0);
  assign pop    = rd_en && exists;
  assign rdata  = slots[rd_q];
  assign count  = cnt_q;

  always_ff @(posedge clk) begin
    if (push) slots[wr_q] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= wr_q + 1'b1;
      if (pop)  rd_q <= rd_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/refill_responder.sv
`timescale 1ns/1ps
module refill_responder #(
  parameter int LINE_WORDS  = 8,
  parameter int WRAP_FIRST  = 1,
  parameter int STORE_WORDS = 256,
  parameter int FIFO_DEPTH  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] req_data,
  input  logic        req_ctrl,
  input  logic        req_exists,
  output logic        req_read,
  output logic [31:0] rsp_data,
  output logic        rsp_exists,
  input  logic        rsp_read
);
  localparam int LW = $clog2(LINE_WORDS);
  localparam int AW = $clog2(STORE_WORDS);
  localparam int PW = $clog2(FIFO_DEPTH);

  // Named internal events, observed by the bound checker.
  logic          fill_push, fill_busy, fifo_full, fifo_pop;
  logic [AW-1:0] fill_idx;
  logic [LW-1:0] fill_crit, fill_beat, fill_slot;
  logic [31:0]   fill_word;
  logic [PW:0]   fifo_count;

  refill_seq #(
    .LINE_WORDS(LINE_WORDS), .WRAP_FIRST(WRAP_FIRST), .STORE_WORDS(STORE_WORDS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_data(req_data), .req_ctrl(req_ctrl), .req_exists(req_exists),
    .req_read(req_read), .fifo_full(fifo_full), .push(fill_push),
    .store_idx(fill_idx), .busy(fill_busy),
    .crit_o(fill_crit), .beat_o(fill_beat), .slot_o(fill_slot)
  );

  refill_store #(.STORE_WORDS(STORE_WORDS)) u_store (
    .idx(fill_idx), .word(fill_word)
  );

  refill_rsp_fifo #(.FIFO_DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(fill_push), .wdata(fill_word), .full(fifo_full),
    .rd_en(rsp_read), .pop(fifo_pop), .rdata(rsp_data),
    .exists(rsp_exists), .count(fifo_count)
  );
endmodule

// File: rtl/refill_responder_chk.sv
`timescale 1ns/1ps
module refill_responder_chk #(
  parameter int LINE_WORDS = 8,
  parameter int WRAP_FIRST = 1,
  parameter int FIFO_DEPTH = 8,
  localparam int LW = $clog2(LINE_WORDS),
  localparam int PW = $clog2(FIFO_DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_exists,
  input logic          req_read,
  input logic          rsp_read,
  input logic          fill_busy,
  input logic          fill_push,
  input logic          fifo_pop,
  input logic [PW:0]   fifo_count,
  input logic [LW-1:0] fill_crit,
  input logic [LW-1:0] fill_beat,
  input logic [LW-1:0] fill_slot
);
  logic [LW-1:0] last_slot;

  always_ff @(posedge clk) begin
    if (!rst_n) last_slot <= '0;
    else if (fill_push) last_slot <= fill_slot;
  end

  p_pop_needs_exists_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_read |-> req_exists);

  p_single_outstanding_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_busy |-> !req_read);

  // R2 (wrap build) and R3 (linear build): first beat of a line
  p_first_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_push && fill_beat == '0) |-> fill_slot == ((WRAP_FIRST != 0) ? fill_crit : '0));

  p_slot_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_push && fill_beat != '0) |-> fill_slot == LW'(last_slot + 1'b1));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= (PW+1)'(FIFO_DEPTH));

  p_count_grows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_push && !fifo_pop) |=> fifo_count == $past(fifo_count) + 1'b1);

  p_empty_read_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_read && fifo_count == '0 && !fill_push) |=> fifo_count == '0);
endmodule

bind refill_responder refill_responder_chk #(
  .LINE_WORDS(LINE_WORDS), .WRAP_FIRST(WRAP_FIRST), .FIFO_DEPTH(FIFO_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_exists(req_exists), .req_read(req_read), .rsp_read(rsp_read),
  .fill_busy(fill_busy), .fill_push(fill_push), .fifo_pop(fifo_pop),
  .fifo_count(fifo_count), .fill_crit(fill_crit), .fill_beat(fill_beat),
  .fill_slot(fill_slot)
);

// File: tb/refill_responder_test.sv
`timescale 1ns/1ps
module refill_responder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic [31:0] req_data [2];
  logic        req_ctrl [2];
  logic        req_exists [2];
  logic        req_read [2];
  logic [31:0] rsp_data [2];
  logic        rsp_exists [2];
  logic        rsp_read [2];

  logic [32:0] req_q [2][$];
  logic [31:0] exp_q [2][$];
  int  pops [2];
  bit  hold [2];
  int  cyc = 0;
  int  checks = 0;
  int  fails = 0;

  // lane 0: 8-word lines, critical word first; lane 1: 4-word lines, linear
  refill_responder #(.LINE_WORDS(8), .WRAP_FIRST(1)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_data(req_data[0]), .req_ctrl(req_ctrl[0]), .req_exists(req_exists[0]),
    .req_read(req_read[0]), .rsp_data(rsp_data[0]), .rsp_exists(rsp_exists[0]),
    .rsp_read(rsp_read[0]));

  refill_responder #(.LINE_WORDS(4), .WRAP_FIRST(0)) uut_lin (
    .clk(clk), .rst_n(rst_n),
    .req_data(req_data[1]), .req_ctrl(req_ctrl[1]), .req_exists(req_exists[1]),
    .req_read(req_read[1]), .rsp_data(rsp_data[1]), .rsp_exists(rsp_exists[1]),
    .rsp_read(rsp_read[1]));

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_word(int idx);
    logic [15:0] w;
    w = 16'(idx & 255);
    return {w, ~w};
  endfunction

  // Driver: queue the request and, for reads, the expected line.
  task automatic send(input int g, input logic [31:0] addr, input logic ctrl);
    int len, idx, base, crit, slot;
    len  = (g == 0) ? 8 : 4;
    idx  = int'(addr[9:2]);
    base = idx & ~(len - 1);
    crit = idx % len;
    req_q[g].push_back({ctrl, addr});
    if (!ctrl) begin
      for (int k = 0; k < len; k++) begin
        slot = (g == 0) ? (crit + k) % len : k;
        exp_q[g].push_back(model_word(base + slot));
      end
    end
  endtask

  task automatic drain(input string tag);
    int n;
    n = 0;
    while ((req_q[0].size() + req_q[1].size() + exp_q[0].size() + exp_q[1].size()) != 0
           && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check(n < 3000, tag, 32'(n), 32'd0);
    repeat (4) @(negedge clk);
    #2;
    check(!rsp_exists[0], "R4 no extra words lane0", 32'(rsp_exists[0]), 32'd0);
    check(!rsp_exists[1], "R4 no extra words lane1", 32'(rsp_exists[1]), 32'd0);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<50000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // Per-lane request driver and response monitor
  for (genvar g = 0; g < 2; g++) begin : lane
    bit taken = 1'b0;
    logic [31:0] want;
    always @(negedge clk) begin
      if (taken) begin
        void'(req_q[g].pop_front());
        pops[g]++;
      end
      if (req_q[g].size() != 0) begin
        req_exists[g] = 1'b1;
        {req_ctrl[g], req_data[g]} = req_q[g][0];
      end else begin
        req_exists[g] = 1'b0;
      end
      rsp_read[g] = !hold[g] && (((cyc + g) % 3) != 0);
      #1;
      taken = rst_n && req_exists[g] && req_read[g];
      if (rst_n && req_read[g] && !req_exists[g])
        check(1'b0, "R5 pop without exists", 32'd1, 32'd0);
      if (rst_n && rsp_read[g] && rsp_exists[g]) begin
        if (exp_q[g].size() == 0) begin
          check(1'b0, "R4 unexpected word", rsp_data[g], 32'd0);
        end else begin
          want = exp_q[g].pop_front();
          check(rsp_data[g] == want, (g == 0) ? "R2 wrap order/data" : "R3 linear order/data",
                rsp_data[g], want);
        end
      end
    end
  end

  initial begin
    int p0, p1;
    for (int g = 0; g < 2; g++) begin
      req_data[g] = '0; req_ctrl[g] = 1'b0; req_exists[g] = 1'b0;
      rsp_read[g] = 1'b0; pops[g] = 0; hold[g] = 1'b0;
    end
    repeat (3) @(negedge clk);
    #2;
    check(!rsp_exists[0], "R1 reset lane0", 32'(rsp_exists[0]), 32'd0);
    check(!rsp_exists[1], "R1 reset lane1", 32'(rsp_exists[1]), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    check(!rsp_exists[0] && !req_read[0], "R1 release lane0", 32'(rsp_exists[0]), 32'd0);

    // R9: reads against an empty buffer for several cycles
    repeat (6) @(negedge clk);
    #2;
    check(!rsp_exists[0], "R9 empty read lane0", 32'(rsp_exists[0]), 32'd0);
    check(!rsp_exists[1], "R9 empty read lane1", 32'(rsp_exists[1]), 32'd0);

    // R2, R3, R4: several addresses, low bits and high bits varied
    for (int g = 0; g < 2; g++) begin
      send(g, 32'h0000_0348, 1'b0);
      send(g, 32'h0000_035D, 1'b0);   // addr bits [1:0] = 01, still a read (R7)
      send(g, 32'h0000_03FC, 1'b0);   // last store word
      send(g, 32'h1000_0340, 1'b0);   // high bits ignored (R4)
      send(g, 32'h0000_0004, 1'b0);
    end
    drain("R2 R3 drain");

    // R7: non-read request discarded, following read intact
    p0 = pops[0]; p1 = pops[1];
    for (int g = 0; g < 2; g++) begin
      send(g, 32'h0000_0200, 1'b1);
      send(g, 32'h0000_0118, 1'b0);
      send(g, 32'h0000_0080, 1'b1);
    end
    drain("R7 drain");
    check(pops[0] == p0 + 3, "R7 lane0 pops", 32'(pops[0] - p0), 32'd3);
    check(pops[1] == p1 + 3, "R7 lane1 pops", 32'(pops[1] - p1), 32'd3);

    // R6, R8: hold the receiver, buffer fills, further requests wait
    hold[0] = 1'b1; hold[1] = 1'b1;
    repeat (2) @(negedge clk);
    p0 = pops[0]; p1 = pops[1];
    send(0, 32'h0000_0024, 1'b0);
    send(0, 32'h0000_0058, 1'b0);
    send(0, 32'h0000_0090, 1'b0);
    send(1, 32'h0000_0024, 1'b0);
    send(1, 32'h0000_0058, 1'b0);
    send(1, 32'h0000_0090, 1'b0);
    send(1, 32'h0000_00C8, 1'b0);
    repeat (60) @(negedge clk);
    #2;
    check(pops[0] == p0 + 2, "R6 lane0 stalled pops", 32'(pops[0] - p0), 32'd2);
    check(pops[1] == p1 + 3, "R6 lane1 stalled pops", 32'(pops[1] - p1), 32'd3);
    check(rsp_exists[0], "R8 held words lane0", 32'(rsp_exists[0]), 32'd1);
    check(rsp_exists[1], "R8 held words lane1", 32'(rsp_exists[1]), 32'd1);
    hold[0] = 1'b0; hold[1] = 1'b0;
    drain("R8 drain");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule